// File: doc/BRIEF.md
# Dual-Bus Ternary Match Counter

This block is a debug monitor that watches two data buses at once. It compares each bus against a ternary pattern, where every bit position can require a 0, require a 1 or be ignored. It keeps three running counts: how many samples matched on the first bus, how many matched on the second bus, and how many samples matched on both buses in the same cycle. Software or a debug controller loads the pattern through two simple write-only registers. It then strobes samples in and reads the counts.

The pattern is held in two words. The care word marks the bit positions that take part in the comparison. The value word gives the expected level at each of those positions. For each bus, a mismatch word is built bit by bit. A bus matches when its mismatch word is entirely zero. Each count is an accumulator that adds its match flag as a carry-in, so it grows by at most one per sample. A synchronous clear input zeroes all three counts.

Top module: `dual_bus_match_counter`

## Requirements
- R1: Mismatch bit i of a bus is 1 only when care bit i is 1 and bus bit i differs from value bit i. A position whose care bit is 0 never causes a mismatch.
- R2: On a rising clock edge with `sampleValid` high and `cntClear` low, `countA` grows by exactly one if bus A has an all-zero mismatch word. Otherwise it holds.
- R3: `countB` follows the same rule as R2 for bus B, independently of bus A.
- R4: `countBoth` grows by one only on a valid sample where bus A and bus B both match. On such a sample, `countA` and `countB` also each grow by one.
- R5: On an edge with `sampleValid` low and `cntClear` low, all three counts keep their values, whatever is on the buses.
- R6: An edge with `cntClear` high leaves all three counts at 0. This takes priority over a valid, matching sample in the same cycle.
- R7: Each count wraps modulo 2^16, so it goes from 0xFFFF to 0x0000.
- R8: An edge with `maskWrEn` high loads `maskWrData` into the care word when `maskWrSel` is 0, and into the value word when `maskWrSel` is 1. A sample in that same cycle is compared against the old pattern. The new pattern applies from the next edge on. `cntClear` leaves the pattern unchanged.
- R9: While `rstN` is low, all counts and both pattern words are 0. After reset, every bit is therefore don't-care and every valid sample matches on both buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cntClear | input | 1 | Synchronous clear of the three counts |
| sampleValid | input | 1 | The buses carry a sample to be counted this cycle |
| busA | input | 16 | First monitored bus |
| busB | input | 16 | Second monitored bus |
| maskWrEn | input | 1 | Pattern word write strobe |
| maskWrSel | input | 1 | Write target: 0 = care word, 1 = value word |
| maskWrData | input | 16 | Data for the pattern word write |
| countA | output | 16 | Matches seen on bus A |
| countB | output | 16 | Matches seen on bus B |
| countBoth | output | 16 | Samples where both buses matched |

## Verification
The assertions assume that `rstN` is released away from the clock edge. They also assume that `sampleValid`, `cntClear`, the buses and the write controls are driven to known levels in every cycle after reset, because the step and hold properties look at them on each edge. The stimulus changes every input only on the falling clock edge and never leaves one floating. It covers the full-care, partial-care and all-don't-care patterns, a clear that collides with a matching sample, a pattern write that collides with a sample, and a long run of valid samples that carries the counts through their wrap point.

// File: rtl/match_mon_pkg.sv
package match_mon_pkg;

  // Target of a pattern word write
  typedef enum logic {
    MASK_CARE  = 1'b0,
    MASK_VALUE = 1'b1
  } maskSel_e;

  // Strobes from control to datapath, one per accumulator plus clear
  typedef struct packed {
    logic clear;
    logic bumpBoth;
    logic bumpB;
    logic bumpA;
  } ctrlStrobe_t;

  localparam int unsigned NUM_BUS = 2;
  localparam int unsigned NUM_CNT = 3;

endpackage

// File: rtl/match_mon_datapath.sv
module match_mon_datapath
  import match_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busA,
  input  logic [DATA_W-1:0] busB,
  input  logic              maskWrEn,
  input  logic              maskWrSel,
  input  logic [DATA_W-1:0] maskWrData,
  input  ctrlStrobe_t       strobe,
  output logic              matchA,
  output logic              matchB,
  output logic [CNT_W-1:0]  countA,
  output logic [CNT_W-1:0]  countB,
  output logic [CNT_W-1:0]  countBoth
);

  logic [DATA_W-1:0] careReg;
  logic [DATA_W-1:0] valueReg;

  // Pattern words: plain write-only registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      careReg  <= '0;
      valueReg <= '0;
    end else if (maskWrEn) begin
      if (maskSel_e'(maskWrSel) == MASK_CARE) careReg  <= maskWrData;
      else                                    valueReg <= maskWrData;
    end
  end

  // Per-bus ternary compare
  logic [DATA_W-1:0] busWord     [NUM_BUS];
  logic [DATA_W-1:0] mismatchWord[NUM_BUS];
  logic [NUM_BUS-1:0] matchFlag;

  assign busWord[0] = busA;
  assign busWord[1] = busB;

  for (genvar g = 0; g < NUM_BUS; g++) begin : gCompare
    assign mismatchWord[g] = (busWord[g] ^ valueReg) & careReg;
    assign matchFlag[g]    = ~|mismatchWord[g];
  end

  assign matchA = matchFlag[0];
  assign matchB = matchFlag[1];

  // Accumulators: count + carry-in, cleared synchronously
  logic [NUM_CNT-1:0] bumpVec;
  logic [CNT_W-1:0]   countVal[NUM_CNT];

  assign bumpVec = {strobe.bumpBoth, strobe.bumpB, strobe.bumpA};

  for (genvar c = 0; c < NUM_CNT; c++) begin : gAccum
    logic [CNT_W-1:0] accReg;
    logic [CNT_W-1:0] accSum;
    assign accSum = accReg + CNT_W'(bumpVec[c]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             accReg <= '0;
      else if (strobe.clear) accReg <= '0;
      else                   accReg <= accSum;
    end
    assign countVal[c] = accReg;
  end

  assign countA    = countVal[0];
  assign countB    = countVal[1];
  assign countBoth = countVal[2];

  // R1: with no care bits set, nothing can mismatch
  assert_dontcare_match_R1: assert property (@(posedge clk) disable iff (!rstN)
    (careReg == '0) |-> (matchA && matchB));

  // R8: a care write lands in the care word on the next edge
  assert_care_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    (maskWrEn && maskWrSel == 1'b0) |=> (careReg == $past(maskWrData)));

  // R6: clear leaves every count at zero
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (countA == '0 && countB == '0 && countBoth == '0));

  // R2: without clear, countA steps by zero or one
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clear |=> (countA == $past(countA) || countA == $past(countA) + CNT_W'(1)));

  // R4: a joint match advances both single counts too
  assert_joint_advances_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && strobe.bumpBoth) |=>
      (countA == $past(countA) + CNT_W'(1) && countB == $past(countB) + CNT_W'(1)));

endmodule

// File: rtl/match_mon_control.sv
module match_mon_control
  import match_mon_pkg::*;
(
  input  logic        cntClear,
  input  logic        sampleValid,
  input  logic        matchA,
  input  logic        matchB,
  output ctrlStrobe_t strobe
);

  logic takeSample;

  // Clear wins over counting; counting needs a valid sample
  assign takeSample = sampleValid && !cntClear;

  always_comb begin
    strobe          = '0;
    strobe.clear    = cntClear;
    strobe.bumpA    = takeSample && matchA;
    strobe.bumpB    = takeSample && matchB;
    strobe.bumpBoth = takeSample && matchA && matchB;
  end

endmodule

// File: rtl/dual_bus_match_counter.sv
module dual_bus_match_counter
  import match_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntClear,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] busA,
  input  logic [DATA_W-1:0] busB,
  input  logic              maskWrEn,
  input  logic              maskWrSel,
  input  logic [DATA_W-1:0] maskWrData,
  output logic [CNT_W-1:0]  countA,
  output logic [CNT_W-1:0]  countB,
  output logic [CNT_W-1:0]  countBoth
);

  ctrlStrobe_t strobe;
  logic        matchA;
  logic        matchB;

  match_mon_control uCtrl (
    .cntClear   (cntClear),
    .sampleValid(sampleValid),
    .matchA     (matchA),
    .matchB     (matchB),
    .strobe     (strobe)
  );

  match_mon_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .busA      (busA),
    .busB      (busB),
    .maskWrEn  (maskWrEn),
    .maskWrSel (maskWrSel),
    .maskWrData(maskWrData),
    .strobe    (strobe),
    .matchA    (matchA),
    .matchB    (matchB),
    .countA    (countA),
    .countB    (countB),
    .countBoth (countBoth)
  );

  // R5: no valid sample and no clear means every count holds
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && !cntClear) |=>
      ($stable(countA) && $stable(countB) && $stable(countBoth)));

endmodule

// File: tb/sim_dual_bus_match_counter.sv
`timescale 1ns/1ps
module sim_dual_bus_match_counter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntClear = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] busA = '0;
  logic [15:0] busB = '0;
  logic        maskWrEn = 1'b0;
  logic        maskWrSel = 1'b0;
  logic [15:0] maskWrData = '0;
  logic [15:0] countA;
  logic [15:0] countB;
  logic [15:0] countBoth;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dual_bus_match_counter u0 (
    .clk(clk), .rstN(rstN), .cntClear(cntClear), .sampleValid(sampleValid),
    .busA(busA), .busB(busB), .maskWrEn(maskWrEn), .maskWrSel(maskWrSel),
    .maskWrData(maskWrData), .countA(countA), .countB(countB), .countBoth(countBoth)
  );

  // Behavioural reference
  logic [15:0] refCare, refValue;
  int unsigned refA, refB, refBoth;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCare = 0; refValue = 0; refA = 0; refB = 0; refBoth = 0;
    end else begin
      bit hitA, hitB;
      hitA = 1'b1; hitB = 1'b1;
      for (int i = 0; i < 16; i++) begin
        if (refCare[i] && busA[i] != refValue[i]) hitA = 1'b0;
        if (refCare[i] && busB[i] != refValue[i]) hitB = 1'b0;
      end
      if (cntClear) begin
        refA = 0; refB = 0; refBoth = 0;
      end else if (sampleValid) begin
        if (hitA) refA = (refA + 1) % 65536;
        if (hitB) refB = (refB + 1) % 65536;
        if (hitA && hitB) refBoth = (refBoth + 1) % 65536;
      end
      if (maskWrEn) begin
        if (maskWrSel) refValue = maskWrData;
        else refCare = maskWrData;
      end
    end
  end

  task automatic checkEq(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareModel();
    checkEq("R2 countA vs model", countA, 16'(refA));
    checkEq("R3 countB vs model", countB, 16'(refB));
    checkEq("R4 countBoth vs model", countBoth, 16'(refBoth));
  endtask

  task automatic stepCycle();
    @(posedge clk);
    @(negedge clk);
    compareModel();
  endtask

  task automatic drive(bit v, logic [15:0] a, logic [15:0] b, bit clr);
    sampleValid = v; busA = a; busB = b; cntClear = clr; maskWrEn = 1'b0;
  endtask

  task automatic writeMask(bit sel, logic [15:0] d);
    maskWrEn = 1'b1; maskWrSel = sel; maskWrData = d;
  endtask

  task automatic expectCounts(string tag, logic [15:0] a, logic [15:0] b, logic [15:0] both);
    checkEq({tag, " countA"}, countA, a);
    checkEq({tag, " countB"}, countB, b);
    checkEq({tag, " countBoth"}, countBoth, both);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    expectCounts("R9 in reset", 16'h0, 16'h0, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    expectCounts("R9 after reset", 16'h0, 16'h0, 16'h0);

    // Full-care pattern 0x1234
    drive(0, 16'h0, 16'h0, 0); writeMask(0, 16'hFFFF); stepCycle();
    drive(0, 16'h0, 16'h0, 0); writeMask(1, 16'h1234); stepCycle();
    drive(1, 16'h1234, 16'h1234, 0); stepCycle();
    expectCounts("R4 joint match", 16'd1, 16'd1, 16'd1);
    drive(1, 16'h1234, 16'h1235, 0); stepCycle();
    expectCounts("R1 R3 one-bit miss on B", 16'd2, 16'd1, 16'd1);

    // Idle cycles with matching buses
    for (int k = 0; k < 3; k++) begin
      drive(0, 16'h1234, 16'h1234, 0); stepCycle();
    end
    expectCounts("R5 idle hold", 16'd2, 16'd1, 16'd1);

    // Partial care: low byte ignored
    drive(0, 16'h0, 16'h0, 0); writeMask(0, 16'hFF00); stepCycle();
    drive(1, 16'h12FF, 16'h1200, 0); stepCycle();
    expectCounts("R1 dont-care low byte", 16'd3, 16'd2, 16'd2);

    // Clear collides with a matching sample
    drive(1, 16'h1200, 16'h1200, 1); stepCycle();
    expectCounts("R6 clear priority", 16'd0, 16'd0, 16'd0);
    drive(1, 16'h12AB, 16'h9900, 0); stepCycle();
    expectCounts("R8 pattern kept across clear", 16'd1, 16'd0, 16'd0);

    // Pattern write in the same cycle as a sample
    drive(1, 16'h12AB, 16'h12AB, 0); writeMask(1, 16'h5600); stepCycle();
    expectCounts("R8 old pattern this cycle", 16'd2, 16'd1, 16'd1);
    drive(1, 16'h12AB, 16'h56CD, 0); stepCycle();
    expectCounts("R8 new pattern next cycle", 16'd2, 16'd2, 16'd1);

    // Random traffic with a sparse pattern, checked against the model
    drive(0, 16'h0, 16'h0, 0); writeMask(0, 16'h0A05); stepCycle();
    for (int k = 0; k < 400; k++) begin
      drive(bit'($urandom_range(0, 3) != 0), 16'($urandom), 16'($urandom),
            bit'($urandom_range(0, 40) == 0));
      if ($urandom_range(0, 30) == 0) writeMask(bit'($urandom_range(0, 1)), 16'($urandom));
      stepCycle();
    end

    // Wrap: clear and drop all care bits, then run 65536 valid samples
    drive(0, 16'h0, 16'h0, 1); writeMask(0, 16'h0000); stepCycle();
    for (int k = 0; k < 65535; k++) begin
      drive(1, 16'($urandom), 16'($urandom), 0);
      @(posedge clk);
      @(negedge clk);
    end
    compareModel();
    expectCounts("R7 at top", 16'hFFFF, 16'hFFFF, 16'hFFFF);
    drive(1, 16'hBEEF, 16'h0F0F, 0); stepCycle();
    expectCounts("R7 wrapped", 16'h0000, 16'h0000, 16'h0000);

    drive(0, 16'h0, 16'h0, 0);
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule